// File: doc/BRIEF.md
# Copy Instruction Micro-Op Emitter

This block takes one 64-byte two-dimensional copy instruction and turns it into a short, ordered program of descriptor micro-ops for a DMA channel. The instruction arrives as sixteen 32-bit beats on a valid/ready input. Once the last beat is in, the word is decoded in one cycle and checked against the format rules. A bad word raises a one-cycle error flag and produces no output. A good word is expanded into a program in a fixed order: control register writes first, then one GENERATE entry, then one DIMPUSH entry per dimension, and finally a doorbell entry that carries the descriptor count.

The micro-ops leave on a tagged bus with a 2-bit kind and a payload. The consumer can stall this bus with ready at any point without losing an entry. The input stays closed from the last beat of a good word until the doorbell of that word has been taken. The number of leading register writes and the direction the channel runs in are build-time parameters.

Top module: `uop_emitter`

## Requirements
- R1: Out of reset, `in_ready` is 1, `uop_valid` is 0 and `err_o` is 0.
- R2: Beat i carries instruction bytes 4i to 4i+3, with the lowest byte in bits 7:0. Multi-byte fields are little-endian. The source leg sits at byte 16 (address 16, steps 24/28, counts 32/34, element size 36) and the destination leg at byte 40 (address 40, steps 48/52, counts 56/58, element size 60).
- R3: A word is rejected unless byte 0 is 0xB8 and byte 1 is 0x10.
- R4: The priority class in bits 2:0 of byte 12 must be 4 or less; the values 5 to 7 reject the word.
- R5: When bit 6 of a leg's address high byte (byte 23 for the source, byte 47 for the destination) is set, that leg's two counts and its second step must all be zero, or the word is rejected.
- R6: The product of the source counts times the source element size must equal the same product on the destination leg, where an element size of 0 means 65536 bytes. Otherwise the word is rejected.
- R7: A rejected word drives `err_o` high for exactly the one cycle after its last beat handshake, and no micro-op is emitted for it.
- R8: A good word emits, in this order: NUM_CTRL_WR register writes (kind 0, payload bits 7:0 the write index from 0, bits 10:8 the priority class), one GENERATE (kind 1), two DIMPUSH (kind 2, dimension 0 first) and one doorbell (kind 3). Nothing follows the doorbell.
- R9: The GENERATE payload holds the leg address in bits 63:0, the element size in bits 79:64, the semaphore index (byte 13) in bits 87:80, the semaphore increment (byte 14) in bits 95:88, and the direction in bit 96 (0 = read from memory into the stream, 1 = write from the stream to memory). With the default read direction, the source leg is used.
- R10: A DIMPUSH payload for dimension d holds the source count in bits 15:0, the destination count in bits 31:16, the signed source step in bits 63:32, the signed destination step in bits 95:64, and d in bit 96.
- R11: The doorbell payload holds the descriptor count in bits 31:0, equal to the product of the two source counts (0 in register-shape mode), and the direction in bit 32.
- R12: While `uop_valid` is high and `uop_ready` is low, the kind and payload hold steady and `uop_valid` stays high.
- R13: `in_ready` is low from the cycle after the last beat of a word until the cycle after the doorbell handshake of that word (for a rejected word, for the single error cycle only).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction beat valid |
| in_ready | output | 1 | Instruction beat accepted |
| in_data | input | 32 | Instruction beat, little-endian bytes |
| uop_valid | output | 1 | Micro-op valid |
| uop_ready | input | 1 | Micro-op taken by the consumer |
| uop_kind | output | 2 | 0 register write, 1 GENERATE, 2 DIMPUSH, 3 doorbell |
| uop_payload | output | 104 | Micro-op payload, layout per kind |
| err_o | output | 1 | One-cycle pulse for a rejected word |

## Verification
Two events can meet in the same cycle: the doorbell handshake that closes one program, and the first beat of the next instruction being offered. The bench keeps `in_valid` high with a beat the whole time a program drains, while `uop_ready` is dropped at random. It checks that no beat is taken before the doorbell has been handshaken, and that exactly the expected entries arrive. Stalls are judged on every cycle, by comparing the held kind and payload with the values seen on the cycle before.

// File: rtl/uop_emit_pkg.sv
package uop_emit_pkg;

  localparam int WORD_BITS  = 512;
  localparam int UOP_PW     = 104;
  localparam int SRC_BASE   = 16;
  localparam int DST_BASE   = 40;
  localparam int SHAPE_BIT  = 62;   // bit 6 of the address high byte
  localparam int PRIO_MAX   = 4;
  localparam logic [7:0] OPC_COPY2D = 8'hB8;
  localparam logic [7:0] LEN_WORDS  = 8'h10;

  typedef enum logic [1:0] {
    UK_REGWR = 2'd0,
    UK_GEN   = 2'd1,
    UK_DIM   = 2'd2,
    UK_BELL  = 2'd3
  } uop_kind_t;

  typedef struct packed {
    logic [63:0] addr;
    logic [31:0] step0;
    logic [31:0] step1;
    logic [15:0] num0;
    logic [15:0] num1;
    logic [15:0] esize;
  } leg_t;

  typedef struct packed {
    logic [2:0] prio;
    logic [7:0] sem;
    logic [7:0] sem_inc;
    leg_t       src;
    leg_t       dst;
  } instr_t;

endpackage

// File: rtl/uop_beat_collect.sv
module uop_beat_collect
  import uop_emit_pkg::*;
#(
  parameter int BEAT_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [BEAT_W-1:0]    in_data,
  output logic                 in_ready,
  input  logic                 busy_i,
  output logic [WORD_BITS-1:0] word_o,
  output logic                 word_vld_o
);

  localparam int N_BEATS = WORD_BITS / BEAT_W;
  localparam int CW      = $clog2(N_BEATS);

  logic [CW-1:0]        cnt_q, cnt_d;
  logic                 full_q, full_d;
  logic [WORD_BITS-1:0] word_q, word_d;
  logic                 accept;
  logic                 last_beat;

  assign in_ready  = !full_q && !busy_i;
  assign accept    = in_valid && in_ready;
  assign last_beat = (cnt_q == CW'(N_BEATS - 1));

  always_comb begin
    word_d = word_q;
    for (int b = 0; b < N_BEATS; b++) begin
      if (accept && (cnt_q == CW'(b))) begin
        word_d[b*BEAT_W +: BEAT_W] = in_data;
      end
    end
  end

  always_comb begin
    cnt_d  = cnt_q;
    full_d = 1'b0;
    if (accept) begin
      if (last_beat) begin
        cnt_d  = '0;
        full_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      full_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      full_q <= full_d;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      word_q <= word_d;
    end
  end

  assign word_o     = word_q;
  assign word_vld_o = full_q;

endmodule

// File: rtl/uop_word_check.sv
module uop_word_check
  import uop_emit_pkg::*;
(
  input  logic [WORD_BITS-1:0] word_i,
  output instr_t               instr_o,
  output logic                 ok_o
);

  function automatic leg_t pick_leg(input logic [WORD_BITS-1:0] w, input int base);
    leg_t l;
    l.addr  = w[8*base        +: 64];
    l.step0 = w[8*(base + 8)  +: 32];
    l.step1 = w[8*(base + 12) +: 32];
    l.num0  = w[8*(base + 16) +: 16];
    l.num1  = w[8*(base + 18) +: 16];
    l.esize = w[8*(base + 20) +: 16];
    return l;
  endfunction

  function automatic logic shape_bad(input leg_t l);
    return l.addr[SHAPE_BIT] && ((l.num0 != 16'd0) || (l.num1 != 16'd0) || (l.step1 != 32'd0));
  endfunction

  function automatic logic [48:0] leg_bytes(input leg_t l);
    logic [31:0] cnt;
    logic [16:0] eff;
    cnt = 32'(l.num0) * 32'(l.num1);
    eff = (l.esize == 16'd0) ? 17'h10000 : {1'b0, l.esize};
    return 49'(cnt) * 49'(eff);
  endfunction

  leg_t src, dst;
  logic hdr_ok, prio_ok, shape_ok, bytes_ok;
  logic unused_bits;

  assign src = pick_leg(word_i, SRC_BASE);
  assign dst = pick_leg(word_i, DST_BASE);

  assign hdr_ok   = (word_i[7:0] == OPC_COPY2D) && (word_i[15:8] == LEN_WORDS);
  assign prio_ok  = (word_i[98:96] <= 3'(PRIO_MAX));
  assign shape_ok = !shape_bad(src) && !shape_bad(dst);
  assign bytes_ok = (leg_bytes(src) == leg_bytes(dst));
  assign ok_o     = hdr_ok && prio_ok && shape_ok && bytes_ok;

  assign instr_o.prio    = word_i[98:96];
  assign instr_o.sem     = word_i[111:104];
  assign instr_o.sem_inc = word_i[119:112];
  assign instr_o.src     = src;
  assign instr_o.dst     = dst;

  assign unused_bits = ^{word_i[95:16], word_i[103:99], word_i[127:120]};

endmodule

// File: rtl/uop_sequencer.sv
module uop_sequencer
  import uop_emit_pkg::*;
#(
  parameter int NUM_CTRL_WR = 1,
  parameter bit GEN_DIR     = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  instr_t            instr_i,
  output logic              busy_o,
  output logic              uop_valid,
  input  logic              uop_ready,
  output uop_kind_t         kind_o,
  output logic [UOP_PW-1:0] payload_o
);

  localparam int NUM_DIMS = 2;
  localparam int TOTAL    = NUM_CTRL_WR + 1 + NUM_DIMS + 1;
  localparam int SW       = $clog2(TOTAL + 1);
  localparam int S_GEN    = NUM_CTRL_WR;
  localparam int S_DIM0   = NUM_CTRL_WR + 1;
  localparam int S_BELL   = TOTAL - 1;

  logic          active_q, active_d;
  logic [SW-1:0] step_q, step_d;
  instr_t        instr_q;
  logic          fire;
  logic          load;
  logic [63:0]   gen_addr;
  logic [15:0]   gen_es;
  logic          unused_fields;

  generate
    if (GEN_DIR == 1'b0) begin : g_rd
      assign gen_addr = instr_q.src.addr;
      assign gen_es   = instr_q.src.esize;
    end else begin : g_wr
      assign gen_addr = instr_q.dst.addr;
      assign gen_es   = instr_q.dst.esize;
    end
  endgenerate

  assign fire = uop_valid && uop_ready;
  assign load = start_i && !active_q;

  always_comb begin
    active_d = active_q;
    step_d   = step_q;
    if (!active_q) begin
      if (start_i) begin
        active_d = 1'b1;
        step_d   = '0;
      end
    end else if (fire) begin
      if (step_q == SW'(S_BELL)) begin
        active_d = 1'b0;
        step_d   = '0;
      end else begin
        step_d = step_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      step_q   <= '0;
    end else begin
      active_q <= active_d;
      step_q   <= step_d;
    end
  end

  always_ff @(posedge clk) begin
    if (load) begin
      instr_q <= instr_i;
    end
  end

  always_comb begin
    kind_o    = UK_BELL;
    payload_o = '0;
    if (step_q < SW'(S_GEN)) begin
      kind_o          = UK_REGWR;
      payload_o[7:0]  = 8'(step_q);
      payload_o[10:8] = instr_q.prio;
    end else if (step_q == SW'(S_GEN)) begin
      kind_o            = UK_GEN;
      payload_o[63:0]   = gen_addr;
      payload_o[79:64]  = gen_es;
      payload_o[87:80]  = instr_q.sem;
      payload_o[95:88]  = instr_q.sem_inc;
      payload_o[96]     = GEN_DIR;
    end else if (step_q == SW'(S_DIM0)) begin
      kind_o           = UK_DIM;
      payload_o[15:0]  = instr_q.src.num0;
      payload_o[31:16] = instr_q.dst.num0;
      payload_o[63:32] = instr_q.src.step0;
      payload_o[95:64] = instr_q.dst.step0;
      payload_o[96]    = 1'b0;
    end else if (step_q == SW'(S_DIM0 + 1)) begin
      kind_o           = UK_DIM;
      payload_o[15:0]  = instr_q.src.num1;
      payload_o[31:16] = instr_q.dst.num1;
      payload_o[63:32] = instr_q.src.step1;
      payload_o[95:64] = instr_q.dst.step1;
      payload_o[96]    = 1'b1;
    end else begin
      kind_o          = UK_BELL;
      payload_o[31:0] = 32'(instr_q.src.num0) * 32'(instr_q.src.num1);
      payload_o[32]   = GEN_DIR;
    end
  end

  assign uop_valid     = active_q;
  assign busy_o        = active_q;
  assign unused_fields = ^{instr_q.src.addr, instr_q.dst.addr, instr_q.src.esize, instr_q.dst.esize};

endmodule

// File: rtl/uop_emitter.sv
module uop_emitter
  import uop_emit_pkg::*;
#(
  parameter int BEAT_W      = 32,
  parameter int NUM_CTRL_WR = 1,
  parameter bit GEN_DIR     = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BEAT_W-1:0] in_data,
  output logic              uop_valid,
  input  logic              uop_ready,
  output logic [1:0]        uop_kind,
  output logic [UOP_PW-1:0] uop_payload,
  output logic              err_o
);

  logic [WORD_BITS-1:0] word;
  logic                 word_vld;
  logic                 busy;
  logic                 word_ok;
  instr_t               instr;
  uop_kind_t            kind;

  uop_beat_collect #(.BEAT_W(BEAT_W)) u_collect (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_data    (in_data),
    .in_ready   (in_ready),
    .busy_i     (busy),
    .word_o     (word),
    .word_vld_o (word_vld)
  );

  uop_word_check u_check (
    .word_i  (word),
    .instr_o (instr),
    .ok_o    (word_ok)
  );

  uop_sequencer #(.NUM_CTRL_WR(NUM_CTRL_WR), .GEN_DIR(GEN_DIR)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (word_vld && word_ok),
    .instr_i   (instr),
    .busy_o    (busy),
    .uop_valid (uop_valid),
    .uop_ready (uop_ready),
    .kind_o    (kind),
    .payload_o (uop_payload)
  );

  assign uop_kind = kind;
  assign err_o    = word_vld && !word_ok;

endmodule

// File: rtl/uop_emitter_chk.sv
module uop_emitter_chk
  import uop_emit_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              in_ready,
  input logic              uop_valid,
  input logic              uop_ready,
  input logic [1:0]        uop_kind,
  input logic [UOP_PW-1:0] uop_payload,
  input logic              err_o
);

  a_r12_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (uop_valid && !uop_ready) |=> (uop_valid && $stable(uop_kind) && $stable(uop_payload)));

  a_r13_closed_busy: assert property (@(posedge clk) disable iff (!rst_n)
    uop_valid |-> !in_ready);

  a_r7_err_single: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> !err_o);

  a_r7_err_silent: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> !uop_valid);

  a_r8_gen_then_dim: assert property (@(posedge clk) disable iff (!rst_n)
    (uop_valid && uop_ready && uop_kind == UK_GEN) |=> (uop_valid && uop_kind == UK_DIM));

  a_r8_bell_last: assert property (@(posedge clk) disable iff (!rst_n)
    (uop_valid && uop_ready && uop_kind == UK_BELL) |=> !uop_valid);

endmodule

bind uop_emitter uop_emitter_chk u_chk (.*);

// File: tb/sim_uop_emitter.sv
module sim_uop_emitter;
  import uop_emit_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int NCW        = 1;
  localparam int TOTAL      = NCW + 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              in_valid = 1'b0;
  logic              in_ready;
  logic [31:0]       in_data = '0;
  logic              uop_valid;
  logic              uop_ready = 1'b0;
  logic [1:0]        uop_kind;
  logic [UOP_PW-1:0] uop_payload;
  logic              err_o;

  uop_emitter #(.BEAT_W(32), .NUM_CTRL_WR(NCW), .GEN_DIR(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .uop_valid(uop_valid), .uop_ready(uop_ready), .uop_kind(uop_kind),
    .uop_payload(uop_payload), .err_o(err_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int bad = 0;
  int cyc = 0;
  logic [7:0] wb [64];
  logic [1:0]        rk [$];
  logic [UOP_PW-1:0] rp [$];
  logic              stall_seen = 1'b0;
  logic [1:0]        stall_kind;
  logic [UOP_PW-1:0] stall_pay;

  task automatic check(input bit cond, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!cond) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++;
      $display("FAIL watchdog actual=%0d expected=finish", cyc);
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  // consumer: random ready, record handshakes, judge stalls (R12)
  always begin
    @(negedge clk);
    uop_ready = rst_n ? (($urandom % 3) != 0) : 1'b0;
    #1;
    if (stall_seen) begin
      check(uop_valid && uop_kind == stall_kind && uop_payload == stall_pay,
            "R12", "held entry", {uop_valid, uop_payload}, {1'b1, stall_pay});
    end
    if (uop_valid && uop_ready) begin
      rk.push_back(uop_kind);
      rp.push_back(uop_payload);
    end
    stall_seen = uop_valid && !uop_ready;
    stall_kind = uop_kind;
    stall_pay  = uop_payload;
  end

  function automatic logic [15:0] g16(input int k);
    return {wb[k+1], wb[k]};
  endfunction
  function automatic logic [31:0] g32(input int k);
    return {g16(k+2), g16(k)};
  endfunction
  function automatic logic [63:0] g64(input int k);
    return {g32(k+4), g32(k)};
  endfunction
  task automatic p16(input int k, input logic [15:0] v);
    wb[k] = v[7:0]; wb[k+1] = v[15:8];
  endtask
  task automatic p32(input int k, input logic [31:0] v);
    p16(k, v[15:0]); p16(k+2, v[31:16]);
  endtask

  function automatic longint unsigned leg_total(input int nb, input int eb);
    longint unsigned e;
    e = (g16(eb) == 16'd0) ? 64'd65536 : 64'(g16(eb));
    return 64'(g16(nb)) * 64'(g16(nb+2)) * e;
  endfunction

  function automatic bit exp_ok();
    if (wb[0] != 8'hB8 || wb[1] != 8'h10) return 1'b0;
    if (wb[12][2:0] > 3'd4) return 1'b0;
    if (wb[23][6] && (g16(32) != 0 || g16(34) != 0 || g32(28) != 0)) return 1'b0;
    if (wb[47][6] && (g16(56) != 0 || g16(58) != 0 || g32(52) != 0)) return 1'b0;
    return leg_total(32, 36) == leg_total(56, 60);
  endfunction

  function automatic logic [UOP_PW-1:0] exp_pay(input int i);
    logic [UOP_PW-1:0] p;
    int d;
    p = '0;
    if (i < NCW) begin
      p[7:0] = 8'(i); p[10:8] = wb[12][2:0];
    end else if (i == NCW) begin
      p[63:0] = g64(16); p[79:64] = g16(36); p[87:80] = wb[13]; p[95:88] = wb[14]; p[96] = 1'b0;
    end else if (i < TOTAL - 1) begin
      d = i - NCW - 1;
      p[15:0] = g16(32 + 2*d); p[31:16] = g16(56 + 2*d);
      p[63:32] = g32(24 + 4*d); p[95:64] = g32(48 + 4*d); p[96] = d[0];
    end else begin
      p[31:0] = 32'(g16(32)) * 32'(g16(34)); p[32] = 1'b0;
    end
    return p;
  endfunction

  function automatic logic [1:0] exp_kind(input int i);
    if (i < NCW) return 2'd0;
    if (i == NCW) return 2'd1;
    if (i < TOTAL - 1) return 2'd2;
    return 2'd3;
  endfunction

  function automatic string tag_of(input int i);
    if (i < NCW) return "R8";
    if (i == NCW) return "R9 R2";
    if (i < TOTAL - 1) return "R10 R2";
    return "R11";
  endfunction

  task automatic rand_word();
    logic [15:0] n0, n1, es;
    for (int k = 0; k < 64; k++) wb[k] = 8'($urandom);
    wb[0] = 8'hB8; wb[1] = 8'h10;
    wb[12][2:0] = 3'($urandom % 5);
    wb[23][6] = 1'b0; wb[47][6] = 1'b0;
    n0 = 16'(1 + $urandom % 8); n1 = 16'(1 + $urandom % 8);
    case ($urandom % 4)
      0: es = 16'd1;
      1: es = 16'd2;
      2: es = 16'd4;
      default: es = 16'd0;
    endcase
    p16(32, n0); p16(34, n1); p16(36, es);
    p16(56, n1); p16(58, n0); p16(60, es);
  endtask

  task automatic send_word(input string req, input bit ok);
    for (int b = 0; b < 16; b++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = {wb[4*b+3], wb[4*b+2], wb[4*b+1], wb[4*b]};
      #2;
      while (!in_ready) begin
        @(negedge clk); #2;
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    #2;
    check(err_o == !ok, ok ? "R7" : req, "error flag after last beat", 128'(err_o), 128'(!ok));
    check(!in_ready, "R13", "input closed after last beat", 128'(in_ready), 128'd0);
  endtask

  task automatic run_word(input string req);
    bit ok;
    bit viol;
    int n;
    ok = exp_ok();
    rk.delete(); rp.delete();
    send_word(req, ok);
    if (!ok) begin
      @(negedge clk); #2;
      check(!err_o, "R7", "error lasts one cycle", 128'(err_o), 128'd0);
      check(in_ready, "R13", "input reopens after error", 128'(in_ready), 128'd1);
      repeat (6) @(negedge clk);
      #2;
      check(rk.size() == 0, "R7", "no entries for rejected word", 128'(rk.size()), 128'd0);
    end else begin
      viol = 1'b0;
      n = 0;
      while (rk.size() < TOTAL && n < 400) begin
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = 32'h0;
        #2;
        if (in_ready && rk.size() < TOTAL) viol = 1'b1;
        n++;
      end
      @(negedge clk);
      in_valid = 1'b0;
      #2;
      check(!viol, "R13", "beat taken before doorbell", 128'(viol), 128'd0);
      check(in_ready, "R13", "input reopens after doorbell", 128'(in_ready), 128'd1);
      repeat (3) @(negedge clk);
      #2;
      check(rk.size() == TOTAL, "R8", "entry count", 128'(rk.size()), 128'(TOTAL));
      for (int i = 0; i < TOTAL && i < rk.size(); i++) begin
        check(rk[i] == exp_kind(i), "R8", "kind order", 128'(rk[i]), 128'(exp_kind(i)));
        check(rp[i] == exp_pay(i), tag_of(i), req, 128'(rp[i]), 128'(exp_pay(i)));
      end
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    #2;
    check(in_ready && !uop_valid && !err_o, "R1", "reset state",
          {in_ready, uop_valid, err_o}, 128'b100);
    rst_n = 1'b1;
    @(negedge clk); #2;
    check(in_ready && !uop_valid && !err_o, "R1", "after release",
          {in_ready, uop_valid, err_o}, 128'b100);

    rand_word(); run_word("R2 plain copy");
    rand_word(); wb[0] = 8'hB9; run_word("R3");
    rand_word(); wb[1] = 8'h0F; run_word("R3");
    rand_word(); wb[12][2:0] = 3'd5; run_word("R4");
    rand_word(); wb[12][2:0] = 3'd7; run_word("R4");
    rand_word(); wb[12][2:0] = 3'd4; run_word("R4 edge");
    // both legs in register-shape mode, all zero: accepted, doorbell count 0
    rand_word(); wb[23][6] = 1'b1; wb[47][6] = 1'b1;
    p16(32, 0); p16(34, 0); p32(28, 0); p16(56, 0); p16(58, 0); p32(52, 0);
    run_word("R5 R11 shape ok");
    rand_word(); wb[23][6] = 1'b1; wb[47][6] = 1'b1;
    p16(32, 5); p16(34, 0); p32(28, 0); p16(56, 0); p16(58, 0); p32(52, 0);
    run_word("R5");
    rand_word(); wb[23][6] = 1'b1; wb[47][6] = 1'b1;
    p16(32, 0); p16(34, 0); p32(28, 0); p16(56, 0); p16(58, 0); p32(52, 32'h40);
    run_word("R5");
    rand_word(); p16(36, 2); p16(60, 4); run_word("R6");
    rand_word(); p16(36, 0); p16(60, 0); run_word("R6 size zero");
    rand_word(); p16(32, 1); p16(34, 1); p16(36, 0);
    p16(56, 16'h8000); p16(58, 1); p16(60, 2); run_word("R6 size zero wide");

    for (int t = 0; t < 40; t++) begin
      rand_word();
      case ($urandom % 8)
        0: wb[12][2:0] = 3'(5 + $urandom % 3);
        1: wb[0] = wb[0] ^ 8'h02;
        2: p16(60, g16(60) + 16'd1);
        default: ;
      endcase
      run_word("R2 random");
    end

    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

endmodule